// File: doc/BRIEF.md
# Auxiliary System Control Register Bank

This block is a small memory-mapped bank of control registers for a workstation I/O controller. It has eight one-per-access slots on a simple register bus: three plain byte registers (configuration, diagnostic and modem control), two byte-wide auxiliary registers with side effects (miscellaneous functions and software power-down), a 16-bit diagnostic LED register, a 32-bit system-control register and a write-only idle-control slot. Each slot accepts exactly one access width. An access of any other width is dropped, and a read of it returns zero.

Some register writes fire side effects as single-cycle strobes on dedicated outputs: a floppy terminal-count pulse, a power-off request, a system-reset request and a CPU-halt request. A power-fail input feeds a sticky flag. The flag is gated by an enable bit in the configuration register, drives the interrupt output, and software clears it by writing a one to a clear bit. There are two resets. The block reset clears only the control registers. The diagnostic, LED and system-control registers sit on the power-on reset, so the reset-status value written before a requested system reset is still there afterwards.

Top module: `auxc_bank`

## Requirements
- R1: Slots 0 (configuration), 1 (diagnostic) and 2 (modem control) each store an 8-bit value written with a byte access (size code 0). A byte read returns that value in rdata[7:0], with the upper bits zero.
- R2: A byte write to slot 3 (misc functions) with bit 1 set gives exactly one high cycle on fd_tc_o, in the cycle after the write. Bit 1 is never stored and always reads 0. Every other bit is stored as written.
- R3: A byte write to slot 4 (power-down) keeps only bit 0 (power-off) and bit 1 (interrupt clear). A read returns the stored power-off bit in bit 0 and the power-fail flag in bit 5; all other bits read 0.
- R4: On every change of pwr_fail_i, the power-fail flag is loaded with (pwr_fail_i AND configuration bit 3). Between changes the flag keeps its value.
- R5: A slot-4 write with bit 1 set clears the power-fail flag. A slot-4 write with bit 1 clear leaves the flag as it was.
- R6: A slot-4 write with bit 0 set gives a one-cycle pulse on pwr_off_o in the cycle after the write.
- R7: irq_o is high exactly when the power-fail flag is 1 and configuration bit 3 is 1.
- R8: A word write (size code 2) to slot 6 with bit 0 set loads the register with 0x00000002 and pulses sys_rst_o for one cycle. A write with bit 0 clear changes nothing. Reads return the stored value.
- R9: rst_n clears configuration, misc functions, power-down (including the flag) and modem control. The diagnostic, LED and system-control registers keep their values and are cleared only by por_n.
- R10: Any byte write to slot 7 (idle control) pulses cpu_halt_o for one cycle. A byte read of slot 7 returns 0.
- R11: Slot 5 requires size 1, slot 6 requires size 2, and every other slot requires size 0. A write of any other size changes no register and fires no pulse. A read of any other size returns 0.
- R12: A halfword write (size code 1) to slot 5 stores 16 bits. The stored value drives led_o and is returned by a halfword read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, async active-low, clears every register |
| rst_n | input | 1 | Block reset, async active-low, clears the control registers only |
| req_valid | input | 1 | Access request in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Slot index 0..7 |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_wdata | input | 32 | Write data, right-aligned |
| rdata | output | 32 | Read data of the current request, 0 when no legal read is in progress |
| pwr_fail_i | input | 1 | Power-fail level, synchronous to clk |
| irq_o | output | 1 | Power-fail interrupt |
| fd_tc_o | output | 1 | Floppy terminal-count strobe |
| pwr_off_o | output | 1 | Power-off request strobe |
| sys_rst_o | output | 1 | System-reset request strobe |
| cpu_halt_o | output | 1 | CPU-halt request strobe |
| led_o | output | 16 | Diagnostic LED register contents |

## Verification
Directed sequences separate the flag's event-driven set from its write-one clear: the power-fail input is raised with the enable off and then on, the flag is cleared while the input stays high, and the enable is dropped to show the interrupt is gated while the flag is kept. A mid-run block reset following a requested system reset tells the power-on-only registers from the control registers. Random traffic mixes all eight slots with legal and illegal widths, random data and power-fail toggles. Wrong-width accesses are checked for zero read data, no register change and no side-effect strobe. Every strobe is checked in the single cycle after its write against a model kept in the bench.

// File: rtl/auxc_pkg.sv
package auxc_pkg;

  localparam int SLOT_COUNT = 8;
  localparam int SLOT_W     = 3;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_CFG   = 3'd0,
    SLOT_DIAG  = 3'd1,
    SLOT_MODEM = 3'd2,
    SLOT_MISC  = 3'd3,
    SLOT_PDOWN = 3'd4,
    SLOT_LED   = 3'd5,
    SLOT_SYS   = 3'd6,
    SLOT_IDLE  = 3'd7
  } slot_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam int CFG_PFEN_BIT  = 3;
  localparam int MISC_TC_BIT   = 1;
  localparam int PD_OFF_BIT    = 0;
  localparam int PD_CLR_BIT    = 1;
  localparam int PD_FLAG_BIT   = 5;
  localparam int SYS_REQ_BIT   = 0;
  localparam int SYS_STAT_BIT  = 1;

  localparam int STROBE_COUNT  = 3;
  localparam int STB_TC        = 0;
  localparam int STB_SRST      = 1;
  localparam int STB_HALT      = 2;

  function automatic acc_size_e width_of(input slot_e s);
    case (s)
      SLOT_LED: width_of = SZ_HALF;
      SLOT_SYS: width_of = SZ_WORD;
      default:  width_of = SZ_BYTE;
    endcase
  endfunction

endpackage

// File: rtl/auxc_decode.sv
module auxc_decode
  import auxc_pkg::*;
#(
  parameter int SLOTS = SLOT_COUNT,
  parameter int AW    = SLOT_W
) (
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [1:0]       req_size,
  output logic [SLOTS-1:0] wr_sel,
  output logic [SLOTS-1:0] rd_sel
);

  logic [SLOTS-1:0] hit;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign hit[i]    = (req_addr == AW'(i)) &&
                       (req_size == 2'(width_of(slot_e'(i))));
    assign wr_sel[i] = req_valid &&  req_write && hit[i];
    assign rd_sel[i] = req_valid && !req_write && hit[i];
  end

endmodule

// File: rtl/auxc_power.sv
module auxc_power
  import auxc_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wd_off,
  input  logic          wd_clr,
  input  logic          pf_in,
  input  logic          pf_enable,
  output logic [BW-1:0] pd_view,
  output logic          irq,
  output logic          off_strobe
);

  logic pf_seen_q, pf_seen_d;
  logic flag_q, flag_d;
  logic off_q, off_d;
  logic stb_q, stb_d;
  logic pf_edge;

  assign pf_edge = (pf_in != pf_seen_q);

  always_comb begin
    pf_seen_d = pf_in;
    flag_d    = flag_q;
    off_d     = off_q;
    stb_d     = 1'b0;
    if (pf_edge) begin
      flag_d = pf_in && pf_enable;
    end
    if (wr_en) begin
      off_d = wd_off;
      stb_d = wd_off;
      if (wd_clr) begin
        flag_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_seen_q <= 1'b0;
      flag_q    <= 1'b0;
      off_q     <= 1'b0;
      stb_q     <= 1'b0;
    end else begin
      pf_seen_q <= pf_seen_d;
      flag_q    <= flag_d;
      off_q     <= off_d;
      stb_q     <= stb_d;
    end
  end

  always_comb begin
    pd_view              = '0;
    pd_view[PD_OFF_BIT]  = off_q;
    pd_view[PD_FLAG_BIT] = flag_q;
  end

  assign irq        = flag_q && pf_enable;
  assign off_strobe = stb_q;

endmodule

// File: rtl/auxc_strobes.sv
module auxc_strobes #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] fire,
  output logic [N-1:0] strobe
);

  logic [N-1:0] stb_q;

  for (genvar i = 0; i < N; i++) begin : g_stb
    logic stb_d;
    assign stb_d = fire[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stb_q[i] <= 1'b0;
      end else begin
        stb_q[i] <= stb_d;
      end
    end
  end

  assign strobe = stb_q;

endmodule

// File: rtl/auxc_bank.sv
module auxc_bank
  import auxc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LED_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [2:0]        req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              pwr_fail_i,
  output logic              irq_o,
  output logic              fd_tc_o,
  output logic              pwr_off_o,
  output logic              sys_rst_o,
  output logic              cpu_halt_o,
  output logic [LED_W-1:0]  led_o
);

  localparam logic [DATA_W-1:0] SYS_STAT_VAL = DATA_W'(1) << SYS_STAT_BIT;
  localparam logic [BYTE_W-1:0] MISC_KEEP    = ~(BYTE_W'(1) << MISC_TC_BIT);

  logic [SLOT_COUNT-1:0]   wr_sel, rd_sel;
  logic                    ctl_rst_n;
  logic [BYTE_W-1:0]       cfg_q, cfg_d, modem_q, modem_d, misc_q, misc_d;
  logic [BYTE_W-1:0]       diag_q, diag_d;
  logic [LED_W-1:0]        led_q, led_d;
  logic [DATA_W-1:0]       sys_q, sys_d;
  logic                    cfg_en, modem_en, misc_en, diag_en, led_en, sys_en;
  logic [BYTE_W-1:0]       pd_view;
  logic [STROBE_COUNT-1:0] fire, strobe;
  logic                    unused_wdata_hi;

  assign ctl_rst_n       = rst_n && por_n;
  assign unused_wdata_hi = ^req_wdata[DATA_W-1:LED_W];

  auxc_decode #(.SLOTS(SLOT_COUNT), .AW(SLOT_W)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .wr_sel    (wr_sel),
    .rd_sel    (rd_sel)
  );

  // Clock enables and next values
  always_comb begin
    cfg_en   = wr_sel[SLOT_CFG];
    diag_en  = wr_sel[SLOT_DIAG];
    modem_en = wr_sel[SLOT_MODEM];
    misc_en  = wr_sel[SLOT_MISC];
    led_en   = wr_sel[SLOT_LED];
    sys_en   = wr_sel[SLOT_SYS] && req_wdata[SYS_REQ_BIT];
    cfg_d    = req_wdata[BYTE_W-1:0];
    diag_d   = req_wdata[BYTE_W-1:0];
    modem_d  = req_wdata[BYTE_W-1:0];
    misc_d   = req_wdata[BYTE_W-1:0] & MISC_KEEP;
    led_d    = req_wdata[LED_W-1:0];
    sys_d    = SYS_STAT_VAL;
  end

  // Control registers: cleared by block reset
  always_ff @(posedge clk or negedge ctl_rst_n) begin
    if (!ctl_rst_n) begin
      cfg_q   <= '0;
      modem_q <= '0;
      misc_q  <= '0;
    end else begin
      if (cfg_en)   cfg_q   <= cfg_d;
      if (modem_en) modem_q <= modem_d;
      if (misc_en)  misc_q  <= misc_d;
    end
  end

  // Retained registers: cleared by power-on reset only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      diag_q <= '0;
      led_q  <= '0;
      sys_q  <= '0;
    end else begin
      if (diag_en) diag_q <= diag_d;
      if (led_en)  led_q  <= led_d;
      if (sys_en)  sys_q  <= sys_d;
    end
  end

  auxc_power #(.BW(BYTE_W)) u_pwr (
    .clk        (clk),
    .rst_n      (ctl_rst_n),
    .wr_en      (wr_sel[SLOT_PDOWN]),
    .wd_off     (req_wdata[PD_OFF_BIT]),
    .wd_clr     (req_wdata[PD_CLR_BIT]),
    .pf_in      (pwr_fail_i),
    .pf_enable  (cfg_q[CFG_PFEN_BIT]),
    .pd_view    (pd_view),
    .irq        (irq_o),
    .off_strobe (pwr_off_o)
  );

  always_comb begin
    fire           = '0;
    fire[STB_TC]   = wr_sel[SLOT_MISC] && req_wdata[MISC_TC_BIT];
    fire[STB_SRST] = wr_sel[SLOT_SYS]  && req_wdata[SYS_REQ_BIT];
    fire[STB_HALT] = wr_sel[SLOT_IDLE];
  end

  auxc_strobes #(.N(STROBE_COUNT)) u_stb (
    .clk    (clk),
    .rst_n  (ctl_rst_n),
    .fire   (fire),
    .strobe (strobe)
  );

  assign fd_tc_o    = strobe[STB_TC];
  assign sys_rst_o  = strobe[STB_SRST];
  assign cpu_halt_o = strobe[STB_HALT];
  assign led_o      = led_q;

  // Read path: zero unless a legal read is in progress
  always_comb begin
    rdata = '0;
    if (|rd_sel) begin
      case (slot_e'(req_addr))
        SLOT_CFG:   rdata = DATA_W'(cfg_q);
        SLOT_DIAG:  rdata = DATA_W'(diag_q);
        SLOT_MODEM: rdata = DATA_W'(modem_q);
        SLOT_MISC:  rdata = DATA_W'(misc_q);
        SLOT_PDOWN: rdata = DATA_W'(pd_view);
        SLOT_LED:   rdata = DATA_W'(led_q);
        SLOT_SYS:   rdata = sys_q;
        default:    rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/auxc_bank_chk.sv
module auxc_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [2:0]  req_addr,
  input logic [1:0]  req_size,
  input logic        wd_b0,
  input logic        wd_b1,
  input logic [31:0] rdata,
  input logic        irq_o,
  input logic        fd_tc_o,
  input logic        pwr_off_o,
  input logic        sys_rst_o,
  input logic        cpu_halt_o
);

  logic [1:0] need;
  logic       fit, wr_ok, rd_ok, rd_bad;

  assign need   = (req_addr == 3'd5) ? 2'd1 : (req_addr == 3'd6) ? 2'd2 : 2'd0;
  assign fit    = (req_size == need);
  assign wr_ok  = req_valid &&  req_write && fit;
  assign rd_ok  = req_valid && !req_write && fit;
  assign rd_bad = req_valid && !req_write && !fit;

  p_tc_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && req_addr == 3'd3 && wd_b1) |=> fd_tc_o);
  p_tc_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fd_tc_o |-> $past(wr_ok && req_addr == 3'd3 && wd_b1));
  p_tc_bit_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && req_addr == 3'd3) |-> !rdata[1]);
  p_off_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && req_addr == 3'd4 && wd_b0) |=> pwr_off_o);
  p_irq_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && req_addr == 3'd4 && irq_o) |-> rdata[5]);
  p_sys_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && req_addr == 3'd6 && wd_b0) |=> sys_rst_o);
  p_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && req_addr == 3'd7) |=> cpu_halt_o);
  p_idle_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && req_addr == 3'd7) |-> (rdata == 32'd0));
  p_bad_size_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bad |-> (rdata == 32'd0));
  p_halt_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt_o |-> $past(wr_ok && req_addr == 3'd7));

endmodule

bind auxc_bank auxc_bank_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_size   (req_size),
  .wd_b0      (req_wdata[0]),
  .wd_b1      (req_wdata[1]),
  .rdata      (rdata),
  .irq_o      (irq_o),
  .fd_tc_o    (fd_tc_o),
  .pwr_off_o  (pwr_off_o),
  .sys_rst_o  (sys_rst_o),
  .cpu_halt_o (cpu_halt_o)
);

// File: tb/sim_auxc_bank.sv
module sim_auxc_bank;

  logic        clk = 1'b0;
  logic        por_n, rst_n;
  logic        req_valid, req_write;
  logic [2:0]  req_addr;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic [31:0] rdata;
  logic        pwr_fail_i;
  logic        irq_o, fd_tc_o, pwr_off_o, sys_rst_o, cpu_halt_o;
  logic [15:0] led_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model
  logic [7:0]  m_cfg, m_diag, m_modem, m_misc;
  logic        m_off, m_flag, m_pf;
  logic [15:0] m_led;
  logic [31:0] m_sys;

  always #2 clk = ~clk;

  auxc_bank u0 (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .rdata(rdata),
    .pwr_fail_i(pwr_fail_i), .irq_o(irq_o), .fd_tc_o(fd_tc_o),
    .pwr_off_o(pwr_off_o), .sys_rst_o(sys_rst_o), .cpu_halt_o(cpu_halt_o),
    .led_o(led_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit legal(input logic [2:0] a, input logic [1:0] s);
    logic [1:0] need;
    need = (a == 3'd5) ? 2'd1 : (a == 3'd6) ? 2'd2 : 2'd0;
    return s == need;
  endfunction

  function automatic string req_of(input logic [2:0] a, input logic [1:0] s);
    if (!legal(a, s)) return "R11";
    case (a)
      3'd3: return "R2";
      3'd4: return "R3";
      3'd5: return "R12";
      3'd6: return "R8";
      3'd7: return "R10";
      default: return "R1";
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [2:0] a, input logic [1:0] s);
    if (!legal(a, s)) return 32'd0;
    case (a)
      3'd0: return {24'd0, m_cfg};
      3'd1: return {24'd0, m_diag};
      3'd2: return {24'd0, m_modem};
      3'd3: return {24'd0, m_misc};
      3'd4: return {26'd0, m_flag, 4'd0, m_off};
      3'd5: return {16'd0, m_led};
      3'd6: return m_sys;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return m_flag && m_cfg[3];
  endfunction

  task automatic do_write(input logic [2:0] a, input logic [1:0] s, input logic [31:0] d);
    bit ok;
    logic e_tc, e_off, e_srst, e_halt;
    ok     = legal(a, s);
    e_tc   = ok && a == 3'd3 && d[1];
    e_off  = ok && a == 3'd4 && d[0];
    e_srst = ok && a == 3'd6 && d[0];
    e_halt = ok && a == 3'd7;
    if (ok) begin
      case (a)
        3'd0: m_cfg   = d[7:0];
        3'd1: m_diag  = d[7:0];
        3'd2: m_modem = d[7:0];
        3'd3: m_misc  = d[7:0] & 8'hFD;
        3'd4: begin m_off = d[0]; if (d[1]) m_flag = 1'b0; end
        3'd5: m_led   = d[15:0];
        3'd6: if (d[0]) m_sys = 32'h2;
        default: ;
      endcase
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = s; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R2",  "fd_tc_o",    {31'd0, fd_tc_o},    {31'd0, e_tc});
    check("R6",  "pwr_off_o",  {31'd0, pwr_off_o},  {31'd0, e_off});
    check("R8",  "sys_rst_o",  {31'd0, sys_rst_o},  {31'd0, e_srst});
    check("R10", "cpu_halt_o", {31'd0, cpu_halt_o}, {31'd0, e_halt});
    check("R7",  "irq_o",      {31'd0, irq_o},      {31'd0, exp_irq()});
    check("R12", "led_o",      {16'd0, led_o},      {16'd0, m_led});
    if (!ok) check("R11", "no strobe on bad size",
                   {28'd0, fd_tc_o, pwr_off_o, sys_rst_o, cpu_halt_o}, 32'd0);
  endtask

  task automatic do_read(input logic [2:0] a, input logic [1:0] s);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = s; req_wdata = 32'd0;
    #1;
    check(req_of(a, s), $sformatf("read slot %0d size %0d", a, s), rdata, exp_read(a, s));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_pf(input logic v);
    @(negedge clk);
    pwr_fail_i = v;
    if (v != m_pf) m_flag = v && m_cfg[3];
    m_pf = v;
    @(negedge clk);
    check("R4", "irq after power-fail change", {31'd0, irq_o}, {31'd0, exp_irq()});
  endtask

  task automatic block_reset();
    set_pf(1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_cfg = 0; m_modem = 0; m_misc = 0; m_off = 0; m_flag = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    por_n = 1'b0; rst_n = 1'b0;
    req_valid = 0; req_write = 0; req_addr = 0; req_size = 0; req_wdata = 0;
    pwr_fail_i = 0;
    m_cfg = 0; m_diag = 0; m_modem = 0; m_misc = 0; m_off = 0; m_flag = 0;
    m_pf = 0; m_led = 0; m_sys = 0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;

    // reset state (R9)
    for (int a = 0; a < 8; a++) do_read(3'(a), (a == 5) ? 2'd1 : (a == 6) ? 2'd2 : 2'd0);
    check("R9", "irq at reset", {31'd0, irq_o}, 32'd0);

    // plain byte registers R1
    do_write(3'd0, 2'd0, 32'hFFFF_FF5A); do_read(3'd0, 2'd0);
    do_write(3'd1, 2'd0, 32'h0000_00C3); do_read(3'd1, 2'd0);
    do_write(3'd2, 2'd0, 32'h0000_0081); do_read(3'd2, 2'd0);

    // terminal count R2
    do_write(3'd3, 2'd0, 32'h0000_00FF); do_read(3'd3, 2'd0);
    do_write(3'd3, 2'd0, 32'h0000_0040); do_read(3'd3, 2'd0);

    // power-down register R3, R5, R6, R4, R7
    do_write(3'd0, 2'd0, 32'h0000_0000);
    do_write(3'd4, 2'd0, 32'h0000_00FC); do_read(3'd4, 2'd0);
    set_pf(1'b1); do_read(3'd4, 2'd0);   // enable off: flag stays 0 (R4)
    set_pf(1'b0);
    do_write(3'd0, 2'd0, 32'h0000_0008);
    set_pf(1'b1); do_read(3'd4, 2'd0);   // flag set, irq high (R7)
    do_write(3'd4, 2'd0, 32'h0000_0001); do_read(3'd4, 2'd0); // flag kept (R5)
    do_write(3'd0, 2'd0, 32'h0000_0000); // irq gated off, flag kept (R7)
    do_read(3'd4, 2'd0);
    do_write(3'd0, 2'd0, 32'h0000_0008);
    do_write(3'd4, 2'd0, 32'h0000_0003); do_read(3'd4, 2'd0); // clear (R5)
    set_pf(1'b0);

    // LED R12, system control R8, idle R10
    do_write(3'd5, 2'd1, 32'hDEAD_BEEF); do_read(3'd5, 2'd1);
    do_write(3'd6, 2'd2, 32'hFFFF_FFFE); do_read(3'd6, 2'd2);
    do_write(3'd6, 2'd2, 32'h0000_0001); do_read(3'd6, 2'd2);
    do_write(3'd7, 2'd0, 32'h0000_00A5); do_read(3'd7, 2'd0);

    // wrong sizes R11
    do_write(3'd0, 2'd2, 32'h0000_0011); do_read(3'd0, 2'd0); do_read(3'd0, 2'd1);
    do_write(3'd7, 2'd1, 32'h0000_0001);
    do_write(3'd6, 2'd0, 32'h0000_0001);
    do_write(3'd5, 2'd3, 32'h0000_1234); do_read(3'd5, 2'd1);

    // selective reset R9
    do_write(3'd2, 2'd0, 32'h0000_0033);
    do_write(3'd3, 2'd0, 32'h0000_0011);
    block_reset();
    for (int a = 0; a < 8; a++) do_read(3'(a), (a == 5) ? 2'd1 : (a == 6) ? 2'd2 : 2'd0);
    check("R9", "led_o retained", {16'd0, led_o}, {16'd0, m_led});

    // random traffic
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [2:0] a;
      logic [1:0] s;
      logic [31:0] d;
      op = $urandom % 10;
      a  = 3'($urandom % 8);
      if (($urandom % 10) < 7) s = (a == 3'd5) ? 2'd1 : (a == 3'd6) ? 2'd2 : 2'd0;
      else s = 2'($urandom % 4);
      d = $urandom;
      if (op < 5) do_write(a, s, d);
      else if (op < 9) do_read(a, s);
      else set_pf(~m_pf);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule